// File: doc/BRIEF.md
# Load-Switch Serial Command Decoder with Diagnosis Capture

This block is the serial control port of a six-channel smart load switch. An external controller sends 16-bit frames on a four-wire serial link. The upper four bits of each frame choose a command and the lower twelve bits carry its data. During the same frame the block shifts out a 16-bit diagnosis word. That word holds a fault code for each channel plus two overtemperature flags.

The serial pins are sampled by the system clock through a synchronizer. A level input chooses which serial clock edge samples the input data; the other edge moves the output data. The block checks each frame when chip select is released. A frame takes effect only if it had exactly 16 sample edges and a known command code. Such a frame updates the configuration registers and clears the latched per-channel fault codes. Any other frame leaves every register and the diagnosis unchanged.

The per-channel fault codes come from the outside, already filtered, and the block latches them. It also drives an active-low fault output. The configuration registers drive the current regulators of channels 1 to 3, the high/low-side setup of channels 4 to 6, the output combine rule, the overtemperature policy, the diag-pin function and the six software on/off bits.

Top module: `lsw_spi_ctrl`

## Requirements
- R1: Frames are shifted most significant bit first on both `sdi` and `sdo`. Bits 15:12 are the command and bits 11:0 are the data. A frame acts only if exactly 16 sample edges occurred while `cs_n` was low, so a frame with 15 or 17 edges changes nothing.
- R2: With `edge_sel` low, `sdi` is sampled on rising `sclk` and `sdo` advances on falling `sclk`. With `edge_sel` high the two edges swap. The first launch edge of a frame does not advance `sdo`.
- R3: `sdo_en` is high only while `cs_n` is low. On the falling edge of `cs_n` the current diagnosis word is loaded, so its bit 15 is on `sdo` before the first sample edge. While `cs_n` is high, `sclk` and `sdi` have no effect.
- R4: Diagnosis word layout: bits [2k+3:2k+2] hold the code of channel k (k = 1..6). The codes are 11 for normal, 10 for overload/overtemperature, 01 for open load and 00 for bypassed switch. Bit 3 is the sticky channel-overtemperature flag, bit 2 is the live `ic_ot` input, and bits 1:0 are always 1.
- R5: Commands 1001, 1010 and 1011 write regulator 1, 2 and 3. The fields are mode = data[11:10], peak = [9:8], off time = [7:6], hold = [5:4] and peak time = [3:1]. Regulator n appears at `reg_cfg[11n-1:11n-11]` in the order {mode, peak, off, hold, peak time}.
- R6: Command 1100 writes the channel configuration. Data[11], [9] and [7] go to `low_side[2]`, `[1]` and `[0]` (channels 6, 5, 4). Data[10], [8] and [6] go to `ol_en[2:0]` in the same channel order. Data[5] goes to `and_sel`, [4] to `latch_sel` and [3] to `ot_pin_sel`.
- R7: Command 1101 sets `sw_on[5:0]` from data[11:6], so channel 6 takes data[11] and channel 1 takes data[6].
- R8: Both `rst_n` low and command 1000 restore the defaults. Each regulator becomes {00,10,01,01,101}. `low_side` becomes 000, `ol_en` 111, the three select bits 0 and `sw_on` 000000.
- R9: Command 1111 clears the diagnosis and changes no configuration register.
- R10: Command codes other than the seven above leave all configuration and the latched diagnosis unchanged.
- R11: When a channel's fault input is not 11, that code is latched and overwrites any earlier code for the channel. A valid frame sets all channel codes back to 11. The channel-overtemperature flag is set by `ch_ot` and survives the clear; only `rst_n` resets it.
- R12: `fault_n` is low exactly while at least one latched channel code differs from 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data in |
| edge_sel | input | 1 | Serial clock edge select |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Output enable for `sdo` (low means high impedance) |
| ch_code | input | 12 | Filtered fault codes, channel k in bits [2k-1:2k-2] |
| ch_ot | input | 1 | Channel overtemperature event |
| ic_ot | input | 1 | Die overtemperature level |
| reg_cfg | output | 33 | Regulator 1..3 settings |
| low_side | output | 3 | Low-side select, channels 4..6 |
| ol_en | output | 3 | Open-load/bypass detect enable, channels 4..6 |
| and_sel | output | 1 | Combine rule select (0 = OR, 1 = AND) |
| latch_sel | output | 1 | Overtemperature policy (0 = restart, 1 = latch) |
| ot_pin_sel | output | 1 | Diag-6 pin function (0 = channel 6, 1 = OT flag) |
| sw_on | output | 6 | Software on bits, channel 1 in bit 0 |
| fault_n | output | 1 | Active-low fault flag |

## Verification
A serial pin edge passes two synchronizer stages and one edge-detect register, so `sdo`, `sdo_en`, the configuration outputs and `fault_n` change three system clocks after the pin edge that causes them. A fault-code input is latched one clock after it is applied. The bench holds each serial clock phase for eight system clocks. It reads `sdo` just before each sample edge and checks every output on a falling system clock edge six clocks after `cs_n` rises, so every result has settled before it is read. Random frames mix valid and undefined commands, bad bit counts, both edge settings and injected faults. Directed cases cover reset, overwrite of a fault code, the sticky flag and the defaults command.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
    localparam int FRAME_W = 16;
    localparam int CMD_W   = 4;
    localparam int NCH     = 6;
    localparam int NREG    = 3;
    localparam int NCFG    = 3;
    localparam int CNT_W   = $clog2(FRAME_W + 2);

    typedef enum logic [CMD_W-1:0] {
        CMD_DEFAULT = 4'b1000,
        CMD_REG1    = 4'b1001,
        CMD_REG2    = 4'b1010,
        CMD_REG3    = 4'b1011,
        CMD_CHCFG   = 4'b1100,
        CMD_ONOFF   = 4'b1101,
        CMD_DIAG    = 4'b1111
    } cmd_e;

    typedef struct packed {
        logic [1:0] mode;
        logic [1:0] peak;
        logic [1:0] toff;
        logic [1:0] hold;
        logic [2:0] tpeak;
    } reg_cfg_t;

    typedef struct packed {
        logic [NCFG-1:0] low_side;
        logic [NCFG-1:0] ol_en;
        logic            and_sel;
        logic            latch_sel;
        logic            flag_sel;
    } ch_cfg_t;

    localparam int REG_W = $bits(reg_cfg_t);

    localparam reg_cfg_t REG_DEFAULT = '{mode: 2'b00, peak: 2'b10, toff: 2'b01,
                                         hold: 2'b01, tpeak: 3'b101};
    localparam ch_cfg_t  CH_DEFAULT  = '{low_side: '0, ol_en: '1, and_sel: 1'b0,
                                         latch_sel: 1'b0, flag_sel: 1'b0};

    function automatic logic cmd_known(input logic [CMD_W-1:0] c);
        case (c)
            CMD_DEFAULT, CMD_REG1, CMD_REG2, CMD_REG3,
            CMD_CHCFG, CMD_ONOFF, CMD_DIAG: return 1'b1;
            default:                         return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/lsw_sync.sv
module lsw_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/lsw_spi_frame.sv
module lsw_spi_frame
    import lsw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               cs_s,
    input  logic               si_s,
    input  logic               edge_sel_s,
    input  logic [FRAME_W-1:0] snap_i,
    output logic               so_o,
    output logic               so_en_o,
    output logic               frame_ok_o,
    output logic [FRAME_W-1:0] frame_o
);
    typedef struct packed {
        logic               sclk_p;
        logic               cs_p;
        logic [FRAME_W-1:0] rx;
        logic [FRAME_W-1:0] tx;
        logic [CNT_W-1:0]   cnt;
    } fr_t;

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

    fr_t  q, d;
    logic cs_fall, cs_rise, smp_edge, lau_edge;

    always_comb begin
        d          = q;
        d.sclk_p   = sclk_s;
        d.cs_p     = cs_s;
        cs_fall    = q.cs_p & ~cs_s;
        cs_rise    = ~q.cs_p & cs_s;
        smp_edge   = edge_sel_s ? (q.sclk_p & ~sclk_s) : (~q.sclk_p & sclk_s);
        lau_edge   = edge_sel_s ? (~q.sclk_p & sclk_s) : (q.sclk_p & ~sclk_s);
        frame_ok_o = cs_rise && (q.cnt == CNT_FULL) && cmd_known(q.rx[FRAME_W-1 -: CMD_W]);
        if (cs_fall) begin
            d.tx  = snap_i;
            d.rx  = '0;
            d.cnt = '0;
        end else if (!cs_s && !q.cs_p) begin
            if (smp_edge) begin
                d.rx = {q.rx[FRAME_W-2:0], si_s};
                if (q.cnt != CNT_OVER) d.cnt = q.cnt + 1'b1;
            end
            if (lau_edge && q.cnt != '0) d.tx = {q.tx[FRAME_W-2:0], 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{sclk_p: 1'b0, cs_p: 1'b1, rx: '0, tx: '1, cnt: '0};
        else        q <= d;
    end

    assign so_o    = q.tx[FRAME_W-1];
    assign so_en_o = ~q.cs_p;
    assign frame_o = q.rx;

    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_OVER);
    a_r3_snapshot_load: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> (q.tx == $past(snap_i)));
    a_r3_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && q.cs_p) |=> $stable(q.rx) && $stable(q.cnt));
endmodule

// File: rtl/lsw_diag.sv
module lsw_diag
    import lsw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*NCH-1:0]   code_i,
    input  logic               ch_ot_i,
    input  logic               ic_ot_i,
    input  logic               clr_i,
    output logic [FRAME_W-1:0] word_o,
    output logic               fault_n_o
);
    typedef struct packed {
        logic [2*NCH-1:0] codes;
        logic             ot;
    } dg_t;

    dg_t q, d;

    always_comb begin
        d    = q;
        d.ot = q.ot | ch_ot_i;
        if (clr_i) d.codes = '1;
        for (int k = 0; k < NCH; k++) begin
            if (code_i[2*k +: 2] != 2'b11) d.codes[2*k +: 2] = code_i[2*k +: 2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{codes: '1, ot: 1'b0};
        else        q <= d;
    end

    assign word_o    = {q.codes, q.ot, ic_ot_i, 2'b11};
    assign fault_n_o = &q.codes;

    a_r11_ot_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q.ot |=> q.ot);
    a_r11_codes_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && (&code_i)) |=> $stable(q.codes));
    a_r12_fault_release: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (&code_i)) |=> fault_n_o);
endmodule

// File: rtl/lsw_spi_ctrl.sv
module lsw_spi_ctrl
    import lsw_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sclk,
    input  logic                 cs_n,
    input  logic                 sdi,
    input  logic                 edge_sel,
    output logic                 sdo,
    output logic                 sdo_en,
    input  logic [2*NCH-1:0]     ch_code,
    input  logic                 ch_ot,
    input  logic                 ic_ot,
    output logic [NREG*REG_W-1:0] reg_cfg,
    output logic [NCFG-1:0]      low_side,
    output logic [NCFG-1:0]      ol_en,
    output logic                 and_sel,
    output logic                 latch_sel,
    output logic                 ot_pin_sel,
    output logic [NCH-1:0]       sw_on,
    output logic                 fault_n
);
    typedef struct packed {
        reg_cfg_t [NREG-1:0] regs;
        ch_cfg_t             ch;
        logic [NCH-1:0]      on;
    } cfg_t;

    localparam cfg_t CFG_DEFAULT = '{regs: {NREG{REG_DEFAULT}}, ch: CH_DEFAULT, on: '0};

    logic [3:0]         pins_s;
    logic               frame_ok;
    logic [FRAME_W-1:0] frame, snap;
    cfg_t               cfg_q, cfg_d;
    logic [CMD_W-1:0]   cmd;
    logic [11:0]        dat;

    lsw_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_i({edge_sel, sdi, cs_n, sclk}),
        .q_o(pins_s)
    );

    lsw_spi_frame u_frame (
        .clk(clk), .rst_n(rst_n),
        .sclk_s(pins_s[0]), .cs_s(pins_s[1]), .si_s(pins_s[2]), .edge_sel_s(pins_s[3]),
        .snap_i(snap), .so_o(sdo), .so_en_o(sdo_en),
        .frame_ok_o(frame_ok), .frame_o(frame)
    );

    lsw_diag u_diag (
        .clk(clk), .rst_n(rst_n),
        .code_i(ch_code), .ch_ot_i(ch_ot), .ic_ot_i(ic_ot),
        .clr_i(frame_ok), .word_o(snap), .fault_n_o(fault_n)
    );

    assign cmd = frame[FRAME_W-1 -: CMD_W];
    assign dat = frame[11:0];

    always_comb begin
        cfg_d = cfg_q;
        if (frame_ok) begin
            case (cmd_e'(cmd))
                CMD_DEFAULT: cfg_d = CFG_DEFAULT;
                CMD_REG1, CMD_REG2, CMD_REG3:
                    cfg_d.regs[cmd[1:0] - 2'd1] = reg_cfg_t'(dat[11:1]);
                CMD_CHCFG: cfg_d.ch = '{low_side: {dat[11], dat[9], dat[7]},
                                        ol_en:    {dat[10], dat[8], dat[6]},
                                        and_sel: dat[5], latch_sel: dat[4], flag_sel: dat[3]};
                CMD_ONOFF: cfg_d.on = dat[11:6];
                default:   cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_DEFAULT;
        else        cfg_q <= cfg_d;
    end

    assign reg_cfg    = cfg_q.regs;
    assign low_side   = cfg_q.ch.low_side;
    assign ol_en      = cfg_q.ch.ol_en;
    assign and_sel    = cfg_q.ch.and_sel;
    assign latch_sel  = cfg_q.ch.latch_sel;
    assign ot_pin_sel = cfg_q.ch.flag_sel;
    assign sw_on      = cfg_q.on;

    a_r10_cfg_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_ok |=> $stable(cfg_q));
    a_r9_diag_only_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok && cmd == CMD_DIAG) |=> $stable(cfg_q));
    a_r12_fault_on_error: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_code != '1) |=> !fault_n);
endmodule

// File: tb/lsw_spi_ctrl_test.sv
module lsw_spi_ctrl_test;
    localparam int H = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sclk = 1'b1, cs_n = 1'b1, sdi = 1'b0, edge_sel = 1'b0;
    logic sdo, sdo_en, ch_ot = 1'b0, ic_ot = 1'b0;
    logic [11:0] ch_code = '1;
    logic [32:0] reg_cfg;
    logic [2:0]  low_side, ol_en;
    logic        and_sel, latch_sel, ot_pin_sel, fault_n;
    logic [5:0]  sw_on;

    int total = 0, bad = 0;
    bit finished = 0;

    logic [10:0] e_reg [3];
    logic [2:0]  e_ls, e_ol;
    logic        e_and, e_lat, e_flg;
    logic [5:0]  e_on;
    logic [11:0] e_codes;
    logic        e_ot;

    always #2.5 clk = ~clk;

    lsw_spi_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi), .edge_sel(edge_sel),
        .sdo(sdo), .sdo_en(sdo_en), .ch_code(ch_code), .ch_ot(ch_ot), .ic_ot(ic_ot),
        .reg_cfg(reg_cfg), .low_side(low_side), .ol_en(ol_en), .and_sel(and_sel),
        .latch_sel(latch_sel), .ot_pin_sel(ot_pin_sel), .sw_on(sw_on), .fault_n(fault_n)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic known(input logic [3:0] c);
        return c == 4'h8 || c == 4'h9 || c == 4'hA || c == 4'hB ||
               c == 4'hC || c == 4'hD || c == 4'hF;
    endfunction

    function automatic logic [15:0] exp_word();
        return {e_codes, e_ot, ic_ot, 2'b11};
    endfunction

    task automatic model_defaults();
        for (int i = 0; i < 3; i++) e_reg[i] = 11'b00_10_01_01_101;
        e_ls = 3'b000; e_ol = 3'b111; e_and = 0; e_lat = 0; e_flg = 0; e_on = '0;
    endtask

    task automatic check_cfg(input string req);
        chk(req, 64'(reg_cfg), 64'({e_reg[2], e_reg[1], e_reg[0]}));
        chk(req, 64'({low_side, ol_en, and_sel, latch_sel, ot_pin_sel}),
                 64'({e_ls, e_ol, e_and, e_lat, e_flg}));
        chk(req, 64'(sw_on), 64'(e_on));
        chk("R12", 64'(fault_n), 64'(&e_codes));
    endtask

    task automatic inject(input logic [11:0] codes, input logic ot);
        @(negedge clk);
        ch_code = codes; ch_ot = ot;
        wait_n(2);
        ch_code = '1; ch_ot = 1'b0;
        for (int k = 0; k < 6; k++)
            if (codes[2*k +: 2] != 2'b11) e_codes[2*k +: 2] = codes[2*k +: 2];
        e_ot = e_ot | ot;
        wait_n(3);
    endtask

    task automatic set_edge(input logic es);
        edge_sel = es; sclk = ~es;
        wait_n(6);
    endtask

    task automatic xfer(input logic [15:0] tx, input int nb, input string req);
        logic [15:0] rx = '1;
        logic [15:0] snap = exp_word();
        cs_n = 1'b0;
        wait_n(H);
        for (int i = 0; i < nb; i++) begin
            sclk = edge_sel;
            sdi  = (i < 16) ? tx[15-i] : 1'b0;
            wait_n(H);
            if (i < 16) rx[15-i] = sdo;
            if (i == 0) chk("R3", 64'(sdo_en), 64'd1);
            sclk = ~edge_sel;
            wait_n(H);
        end
        cs_n = 1'b1;
        wait_n(6);
        chk("R3", 64'(sdo_en), 64'd0);
        if (nb == 16) chk("R4", 64'(rx), 64'(snap));
        if (nb == 16 && known(tx[15:12])) begin
            e_codes = '1;
            case (tx[15:12])
                4'h8: model_defaults();
                4'h9, 4'hA, 4'hB: e_reg[tx[13:12]-1] = tx[11:1];
                4'hC: begin
                    e_ls = {tx[11], tx[9], tx[7]}; e_ol = {tx[10], tx[8], tx[6]};
                    e_and = tx[5]; e_lat = tx[4]; e_flg = tx[3];
                end
                4'hD: e_on = tx[11:6];
                default: ;
            endcase
        end
        check_cfg(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog timeout");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        model_defaults();
        e_codes = '1; e_ot = 1'b0;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(4);
        // R8 reset defaults, R3 idle output disabled
        check_cfg("R8");
        chk("R3", 64'(sdo_en), 64'd0);

        // R5 regulator 2 write, R7 on bits, mode edge_sel=0 (R2)
        xfer(16'hA_5AE, 16, "R5");
        xfer(16'hD_A40, 16, "R7");
        // R6 channel config
        xfer(16'hC_6B8, 16, "R6");

        // R11 latching, overwrite, sticky OT, R12 fault
        inject(12'b11_11_11_11_11_10, 1'b0);
        chk("R12", 64'(fault_n), 64'd0);
        inject(12'b11_11_11_11_11_01, 1'b1);
        ic_ot = 1'b1;
        // R10 undefined command keeps diag and config
        xfer(16'h0_FFF, 16, "R10");
        chk("R11", 64'(fault_n), 64'd0);
        // R1 short and long frames have no effect
        xfer(16'hD_FC0, 15, "R1");
        xfer(16'hD_FC0, 17, "R1");
        chk("R1", 64'(sw_on), 64'(e_on));
        // R9 diagnosis only clears codes, keeps config; OT flag survives (R11)
        xfer(16'hF_FFF, 16, "R9");
        ic_ot = 1'b0;
        xfer(16'hF_000, 16, "R11");

        // R2 opposite edge setting
        set_edge(1'b1);
        xfer(16'h9_F3E, 16, "R2");
        inject(12'b00_11_11_11_11_11, 1'b0);
        xfer(16'hB_123, 16, "R5");
        // R8 defaults command
        xfer(16'h8_FFF, 16, "R8");
        set_edge(1'b0);

        // R3 pins ignored while cs_n is high
        for (int i = 0; i < 8; i++) begin
            sdi = ~sdi; sclk = ~sclk; wait_n(H);
        end
        sclk = 1'b1; wait_n(6);
        xfer(16'hF_000, 16, "R3");

        // random mix
        for (int n = 0; n < 70; n++) begin
            logic [3:0]  c;
            logic [15:0] f;
            int          nb, r;
            if ($urandom_range(0, 2) == 0) begin
                logic [11:0] cv = '1;
                cv[2*$urandom_range(0, 5) +: 2] = 2'($urandom_range(0, 2));
                inject(cv, $urandom_range(0, 9) == 0);
            end
            if ($urandom_range(0, 7) == 0) set_edge(~edge_sel);
            r = $urandom_range(0, 9);
            case (r)
                0: c = 4'h8; 1: c = 4'h9; 2: c = 4'hA; 3: c = 4'hB;
                4: c = 4'hC; 5: c = 4'hD; 6: c = 4'hF;
                default: c = 4'($urandom_range(0, 15));
            endcase
            f  = {c, 12'($urandom)};
            nb = ($urandom_range(0, 9) == 0) ? 15 + 2 * $urandom_range(0, 1) : 16;
            xfer(f, nb, (c == 4'hC) ? "R6" : (c == 4'hD) ? "R7" :
                        (c[3:2] == 2'b10 && c != 4'h8) ? "R5" : "R10");
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule